// File: doc/BRIEF.md
# Column-Scan Gradient-Adjusted Predictor and Residual Mapper

This block is the prediction front end of a lossless image coder that walks the image in short vertical strips. For every pixel it receives the current value together with seven causal neighbours that an upstream fetch unit has already gathered. Two of them lie above the pixel in its own column: `nb_n` directly above and `nb_nn` two above. Five lie in the two columns already coded: `nb_w` beside the pixel, `nb_wn` above that, `nb_ws` below that, `nb_ww` two columns back, and `nb_wsw` below `nb_ww`.

The block measures the activity along and across the scan direction. From the difference between those two sums it chooses one of seven prediction rules, which blend the vertical neighbour, the side neighbour and a gradient-corrected average. The prediction is clamped to the pixel range. The signed residual is then folded into a non-negative code word. The fold is aware of the pixel range, so the code always fits in the pixel width.

Pixels flagged as reference samples skip prediction so that a downstream coder can emit them raw. The block accepts one pixel per clock and has a fixed latency of three cycles.

Top module: `vgap_predict_map`

## Requirements
- R1: The column gradient is gv = |nb_nn−nb_n| + |nb_w−nb_wn| + |nb_w−nb_ws|. The cross gradient is gc = |nb_n−nb_wn| + |nb_w−nb_ww| + |nb_ws−nb_wsw|. The steering value is d = gc − gv.
- R2: When d > 80 the prediction is nb_n. When d < −80 the prediction is nb_w.
- R3: When −8 ≤ d ≤ 8 the prediction is the base b = floor((nb_n+nb_w)/2) + floor((nb_ws−nb_wn)/4).
- R4: The other bands refine b as follows.
  - For 32 < d ≤ 80 the prediction is floor((b+nb_n)/2).
  - For 8 < d ≤ 32 it is floor((3b+nb_n)/4).
  - For −80 ≤ d < −32 it is floor((b+nb_w)/2).
  - For −32 ≤ d < −8 it is floor((3b+nb_w)/4).
- R5: Every division rounds toward minus infinity. The final prediction is clamped to 0..255.
- R6: The fold limit is t = min(p, 255−p), where p is the clamped prediction.
- R7: With residual e = pixel − p, the code is defined in three cases.
  - If 0 ≤ e ≤ t the code is 2e.
  - If −t ≤ e < 0 the code is 2|e|−1.
  - Otherwise the code is t+|e|.
  - The code always fits in 8 bits.
- R8: When in_ref is 1, out_pred and out_code both equal the input pixel, and out_ref is 1.
- R9: out_valid and out_ref reproduce in_valid and in_ref exactly three clock edges later. One pixel is accepted on every clock edge.
- R10: While reset is held, and for the first three edges after it is released, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel strobe |
| in_ref | input | 1 | Pixel is a reference sample (bypass) |
| in_pix | input | 8 | Current pixel |
| nb_n | input | 8 | Neighbour directly above |
| nb_nn | input | 8 | Neighbour two above |
| nb_w | input | 8 | Neighbour in previous column, same row |
| nb_wn | input | 8 | Previous column, one row above |
| nb_ws | input | 8 | Previous column, one row below |
| nb_ww | input | 8 | Two columns back, same row |
| nb_wsw | input | 8 | Two columns back, one row below |
| out_valid | output | 1 | Output strobe, three cycles after in_valid |
| out_ref | output | 1 | Delayed reference flag |
| out_pred | output | 8 | Clamped prediction (pixel when reference) |
| out_code | output | 8 | Folded residual (pixel when reference) |

## Verification
Range clamping and the edge case of the fold can fall in the same cycle. When the gradient-corrected base runs below 0 or above 255, the clamped prediction sits at the range limit. The fold limit is then zero, so the code must collapse to |e| even for a residual that would otherwise be folded.

The bench builds both cases directly, using neighbour sets with a steep nb_wn/nb_ws step and flat gradients. It also uses smooth random neighbourhoods that often land near the extremes. Every such output is judged against a bench model that performs the clamp and the fold with floor division on plain integers.

// File: rtl/vgap_pkg.sv
// Package: vgap_pkg
// Shared types for the column-scan predictor. The band code is produced by the
// gradient stage and consumed by the refinement stage.
package vgap_pkg;
    // Prediction rule chosen from the steering value d = gc - gv
    typedef enum logic [2:0] {
        BAND_BASE   = 3'd0,
        BAND_N      = 3'd1,
        BAND_W      = 3'd2,
        BAND_N_HALF = 3'd3,
        BAND_N_QTR  = 3'd4,
        BAND_W_HALF = 3'd5,
        BAND_W_QTR  = 3'd6
    } band_e;
endpackage

// File: rtl/vgap_grad_stage.sv
// Module: vgap_grad_stage
// Stage 1 of 3. Forms the six absolute differences, the two gradient sums, the
// steering value and the unrefined base predictor, then classifies the band.
// Assumes: neighbours are already aligned with in_pix in the same cycle.
module vgap_grad_stage
    import vgap_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int THR_HI  = 80,
    parameter int THR_MID = 32,
    parameter int THR_LO  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_ref,
    input  logic [PIX_W-1:0]          in_pix,
    input  logic [PIX_W-1:0]          nb_n,
    input  logic [PIX_W-1:0]          nb_nn,
    input  logic [PIX_W-1:0]          nb_w,
    input  logic [PIX_W-1:0]          nb_wn,
    input  logic [PIX_W-1:0]          nb_ws,
    input  logic [PIX_W-1:0]          nb_ww,
    input  logic [PIX_W-1:0]          nb_wsw,
    output logic                      s1_valid,
    output logic                      s1_ref,
    output logic [PIX_W-1:0]          s1_pix,
    output logic [PIX_W-1:0]          s1_n,
    output logic [PIX_W-1:0]          s1_w,
    output band_e                     s1_band,
    output logic signed [PIX_W+4:0]   s1_base
);
    localparam int GRAD_W = PIX_W + 2;   // sum of three PIX_W magnitudes
    localparam int DIFF_W = PIX_W + 3;   // signed gc - gv
    localparam int WIDE_W = PIX_W + 5;   // signed predictor arithmetic
    localparam int NPAIR  = 6;

    localparam logic signed [DIFF_W-1:0] T_HI  = DIFF_W'(THR_HI);
    localparam logic signed [DIFF_W-1:0] T_MID = DIFF_W'(THR_MID);
    localparam logic signed [DIFF_W-1:0] T_LO  = DIFF_W'(THR_LO);

    logic [PIX_W-1:0]         op_a [NPAIR];
    logic [PIX_W-1:0]         op_b [NPAIR];
    logic [PIX_W-1:0]         mag  [NPAIR];
    logic [GRAD_W-1:0]        g_col, g_crs;
    logic signed [DIFF_W-1:0] steer;
    logic signed [WIDE_W-1:0] half_sum, quarter_gap, base_c;
    band_e                    band_c;

    // Operand pairs: 0..2 feed the column gradient, 3..5 the cross gradient
    always_comb begin
        op_a[0] = nb_nn; op_b[0] = nb_n;
        op_a[1] = nb_w;  op_b[1] = nb_wn;
        op_a[2] = nb_w;  op_b[2] = nb_ws;
        op_a[3] = nb_n;  op_b[3] = nb_wn;
        op_a[4] = nb_w;  op_b[4] = nb_ww;
        op_a[5] = nb_ws; op_b[5] = nb_wsw;
    end

    // One absolute-difference unit per operand pair
    for (genvar gi = 0; gi < NPAIR; gi++) begin : g_absdiff
        assign mag[gi] = (op_a[gi] >= op_b[gi]) ? (op_a[gi] - op_b[gi])
                                                : (op_b[gi] - op_a[gi]);
    end

    // Gradient sums and the signed steering value
    always_comb begin
        g_col = GRAD_W'(mag[0]) + GRAD_W'(mag[1]) + GRAD_W'(mag[2]);
        g_crs = GRAD_W'(mag[3]) + GRAD_W'(mag[4]) + GRAD_W'(mag[5]);
        steer = $signed(DIFF_W'(g_crs)) - $signed(DIFF_W'(g_col));
    end

    // Base predictor: floor halves and quarters via arithmetic shifts
    always_comb begin
        half_sum    = ($signed(WIDE_W'(nb_n)) + $signed(WIDE_W'(nb_w))) >>> 1;
        quarter_gap = ($signed(WIDE_W'(nb_ws)) - $signed(WIDE_W'(nb_wn))) >>> 2;
        base_c      = half_sum + quarter_gap;
    end

    // Band classification in priority order: outer bands first
    always_comb begin
        if (steer > T_HI)             band_c = BAND_N;
        else if (steer < -T_HI)       band_c = BAND_W;
        else if (steer > T_MID)       band_c = BAND_N_HALF;
        else if (steer > T_LO)        band_c = BAND_N_QTR;
        else if (steer < -T_MID)      band_c = BAND_W_HALF;
        else if (steer < -T_LO)       band_c = BAND_W_QTR;
        else                          band_c = BAND_BASE;
    end

    // Stage register; control bits reset, data follows freely
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_ref   <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s1_ref   <= in_ref;
        end
        s1_pix  <= in_pix;
        s1_n    <= nb_n;
        s1_w    <= nb_w;
        s1_band <= band_c;
        s1_base <= base_c;
    end
endmodule

// File: rtl/vgap_refine_stage.sv
// Module: vgap_refine_stage
// Stage 2 of 3. Applies the band rule to the base predictor and clamps the
// result to the pixel range. Reference pixels predict themselves.
// Assumes: s1_base carries the floor-rounded base from stage 1.
module vgap_refine_stage
    import vgap_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      s1_valid,
    input  logic                      s1_ref,
    input  logic [PIX_W-1:0]          s1_pix,
    input  logic [PIX_W-1:0]          s1_n,
    input  logic [PIX_W-1:0]          s1_w,
    input  band_e                     s1_band,
    input  logic signed [PIX_W+4:0]   s1_base,
    output logic                      s2_valid,
    output logic                      s2_ref,
    output logic [PIX_W-1:0]          s2_pix,
    output logic [PIX_W-1:0]          s2_pred
);
    localparam int WIDE_W = PIX_W + 5;
    localparam logic signed [WIDE_W-1:0] MAXV = WIDE_W'((1 << PIX_W) - 1);

    logic signed [WIDE_W-1:0] n_s, w_s, raw;
    logic [PIX_W-1:0]         clamped;

    // Band rule; every division is a floor shift on a signed value
    always_comb begin
        n_s = $signed(WIDE_W'(s1_n));
        w_s = $signed(WIDE_W'(s1_w));
        unique case (s1_band)
            BAND_N:      raw = n_s;
            BAND_W:      raw = w_s;
            BAND_N_HALF: raw = (s1_base + n_s) >>> 1;
            BAND_N_QTR:  raw = (s1_base + s1_base + s1_base + n_s) >>> 2;
            BAND_W_HALF: raw = (s1_base + w_s) >>> 1;
            BAND_W_QTR:  raw = (s1_base + s1_base + s1_base + w_s) >>> 2;
            default:     raw = s1_base;
        endcase
    end

    // Clamp into 0 .. 2^PIX_W-1
    always_comb begin
        if (raw < 0)          clamped = '0;
        else if (raw > MAXV)  clamped = MAXV[PIX_W-1:0];
        else                  clamped = raw[PIX_W-1:0];
    end

    // Stage register; reference pixels carry themselves as prediction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_ref   <= 1'b0;
        end else begin
            s2_valid <= s1_valid;
            s2_ref   <= s1_ref;
        end
        s2_pix  <= s1_pix;
        s2_pred <= s1_ref ? s1_pix : clamped;
    end
endmodule

// File: rtl/vgap_fold_stage.sv
// Module: vgap_fold_stage
// Stage 3 of 3. Folds the signed residual into a non-negative code using the
// distance from the prediction to the nearer end of the pixel range.
// Assumes: s2_pred is already clamped into the pixel range.
module vgap_fold_stage #(
    parameter int PIX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s2_valid,
    input  logic              s2_ref,
    input  logic [PIX_W-1:0]  s2_pix,
    input  logic [PIX_W-1:0]  s2_pred,
    output logic              out_valid,
    output logic              out_ref,
    output logic [PIX_W-1:0]  out_pred,
    output logic [PIX_W-1:0]  out_code
);
    localparam int RES_W = PIX_W + 1;
    localparam logic [PIX_W-1:0] MAXP = '1;

    logic signed [RES_W-1:0] resid;
    logic [PIX_W-1:0]        mag, room_hi, theta;
    logic [RES_W-1:0]        code_w;

    // Residual magnitude and the fold limit
    always_comb begin
        resid   = $signed({1'b0, s2_pix}) - $signed({1'b0, s2_pred});
        mag     = resid[RES_W-1] ? PIX_W'(-resid) : resid[PIX_W-1:0];
        room_hi = MAXP - s2_pred;
        theta   = (s2_pred <= room_hi) ? s2_pred : room_hi;
    end

    // Three-way fold: even for small positive, odd for small negative, linear beyond
    always_comb begin
        if (mag > theta)
            code_w = RES_W'(theta) + RES_W'(mag);
        else if (resid[RES_W-1])
            code_w = {mag, 1'b0} - RES_W'(1);
        else
            code_w = {mag, 1'b0};
    end

    // Output register; reference pixels emit the raw value as code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ref   <= 1'b0;
        end else begin
            out_valid <= s2_valid;
            out_ref   <= s2_ref;
        end
        out_pred <= s2_pred;
        out_code <= s2_ref ? s2_pix : code_w[PIX_W-1:0];
    end
endmodule

// File: rtl/vgap_predict_map.sv
// Module: vgap_predict_map
// Top of the column-scan predictor: gradient stage, refinement stage, fold
// stage. Fixed latency of three cycles, one pixel per clock, no stalls.
// Assumes: the neighbour fetch unit presents all seven neighbours with in_pix.
module vgap_predict_map
    import vgap_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int THR_HI  = 80,
    parameter int THR_MID = 32,
    parameter int THR_LO  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_ref,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic [PIX_W-1:0]  nb_n,
    input  logic [PIX_W-1:0]  nb_nn,
    input  logic [PIX_W-1:0]  nb_w,
    input  logic [PIX_W-1:0]  nb_wn,
    input  logic [PIX_W-1:0]  nb_ws,
    input  logic [PIX_W-1:0]  nb_ww,
    input  logic [PIX_W-1:0]  nb_wsw,
    output logic              out_valid,
    output logic              out_ref,
    output logic [PIX_W-1:0]  out_pred,
    output logic [PIX_W-1:0]  out_code
);
    logic                     s1_valid, s1_ref, s2_valid, s2_ref;
    logic [PIX_W-1:0]         s1_pix, s1_n, s1_w, s2_pix, s2_pred;
    band_e                    s1_band;
    logic signed [PIX_W+4:0]  s1_base;

    vgap_grad_stage #(
        .PIX_W(PIX_W), .THR_HI(THR_HI), .THR_MID(THR_MID), .THR_LO(THR_LO)
    ) grad_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ref(in_ref),
        .in_pix(in_pix), .nb_n(nb_n), .nb_nn(nb_nn), .nb_w(nb_w),
        .nb_wn(nb_wn), .nb_ws(nb_ws), .nb_ww(nb_ww), .nb_wsw(nb_wsw),
        .s1_valid(s1_valid), .s1_ref(s1_ref), .s1_pix(s1_pix),
        .s1_n(s1_n), .s1_w(s1_w), .s1_band(s1_band), .s1_base(s1_base)
    );

    vgap_refine_stage #(.PIX_W(PIX_W)) refine_i (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_ref(s1_ref),
        .s1_pix(s1_pix), .s1_n(s1_n), .s1_w(s1_w), .s1_band(s1_band),
        .s1_base(s1_base), .s2_valid(s2_valid), .s2_ref(s2_ref),
        .s2_pix(s2_pix), .s2_pred(s2_pred)
    );

    vgap_fold_stage #(.PIX_W(PIX_W)) fold_i (
        .clk(clk), .rst_n(rst_n), .s2_valid(s2_valid), .s2_ref(s2_ref),
        .s2_pix(s2_pix), .s2_pred(s2_pred), .out_valid(out_valid),
        .out_ref(out_ref), .out_pred(out_pred), .out_code(out_code)
    );
endmodule

// File: rtl/vgap_checker.sv
// Module: vgap_checker
// Port-level properties of vgap_predict_map, bound to every instance.
// A small warm-up counter keeps every $past inside the time since reset.
module vgap_checker #(
    parameter int PIX_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ref,
    input logic [PIX_W-1:0]  in_pix,
    input logic              out_valid,
    input logic              out_ref,
    input logic [PIX_W-1:0]  out_pred,
    input logic [PIX_W-1:0]  out_code
);
    logic [1:0] warm;

    // Counts edges since reset release, saturating at three
    always_ff @(posedge clk) begin
        if (!rst_n)             warm <= 2'd0;
        else if (warm != 2'd3)  warm <= warm + 2'd1;
    end

    p_warmup_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd3) |-> !out_valid);

    p_valid_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_ref_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) && out_valid |-> (out_ref == $past(in_ref, 3)));

    p_ref_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) && out_valid && out_ref |->
            (out_code == $past(in_pix, 3)) && (out_pred == $past(in_pix, 3)));

    p_zero_code_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) && out_valid && !out_ref && (out_code == '0) |->
            (out_pred == $past(in_pix, 3)));

    p_floor_theta_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) && out_valid && !out_ref && (out_pred == '0) |->
            (out_code == $past(in_pix, 3)));
endmodule

bind vgap_predict_map vgap_checker #(.PIX_W(PIX_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ref(in_ref),
    .in_pix(in_pix), .out_valid(out_valid), .out_ref(out_ref),
    .out_pred(out_pred), .out_code(out_code)
);

// File: tb/vgap_predict_map_tb_top.sv
// Bench for vgap_predict_map: directed band edges and clamp cases, then
// seeded random traffic; every output compared against an integer model.
module vgap_predict_map_tb_top;
    localparam int NMAX = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_ref = 1'b0;
    logic [7:0] in_pix = '0, nb_n = '0, nb_nn = '0, nb_w = '0;
    logic [7:0] nb_wn = '0, nb_ws = '0, nb_ww = '0, nb_wsw = '0;
    logic       out_valid, out_ref;
    logic [7:0] out_pred, out_code;

    int    n_checks = 0, n_errors = 0, idx = 0;
    bit    finished = 1'b0;
    bit    ev [NMAX];
    bit    eref [NMAX];
    int    epred [NMAX];
    int    ecode [NMAX];
    string etag [NMAX];

    always #2 clk = ~clk;

    vgap_predict_map dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ref(in_ref),
        .in_pix(in_pix), .nb_n(nb_n), .nb_nn(nb_nn), .nb_w(nb_w),
        .nb_wn(nb_wn), .nb_ws(nb_ws), .nb_ww(nb_ww), .nb_wsw(nb_wsw),
        .out_valid(out_valid), .out_ref(out_ref), .out_pred(out_pred),
        .out_code(out_code)
    );

    function automatic int iabs(int a);
        return (a < 0) ? -a : a;
    endfunction

    function automatic int fdiv(int a, int b);
        if (a >= 0) return a / b;
        return -((-a + b - 1) / b);
    endfunction

    task automatic check(string tag, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d (sample %0d)", tag, got, exp, idx);
        end
    endtask

    // Compare the outputs of the sample driven three negedges ago
    task automatic check_out();
        int j;
        j = idx - 3;
        if (j < 0) begin
            check("R10 out_valid after reset", int'(out_valid), 0);
        end else begin
            check("R9 out_valid latency", int'(out_valid), int'(ev[j]));
            if (ev[j]) begin
                check("R9 out_ref latency", int'(out_ref), int'(eref[j]));
                check({etag[j], " prediction"}, int'(out_pred), epred[j]);
                check(eref[j] ? "R8 bypass code" : "R7 folded code",
                      int'(out_code), ecode[j]);
            end
        end
    endtask

    // Reference model computed from the requirement text
    task automatic model(bit v, bit r, int px, int n, int nn, int w,
                         int wn, int ws, int ww, int wsw);
        int gv, gc, d, b, p, e, t;
        string tg;
        gv = iabs(nn - n) + iabs(w - wn) + iabs(w - ws);
        gc = iabs(n - wn) + iabs(w - ww) + iabs(ws - wsw);
        d  = gc - gv;
        b  = fdiv(n + w, 2) + fdiv(ws - wn, 4);
        if (d > 80)       begin p = n;                   tg = "R1 R2 above-band"; end
        else if (d < -80) begin p = w;                   tg = "R1 R2 side-band";  end
        else if (d > 32)  begin p = fdiv(b + n, 2);      tg = "R4 n-half";        end
        else if (d > 8)   begin p = fdiv(3 * b + n, 4);  tg = "R4 n-quarter";     end
        else if (d < -32) begin p = fdiv(b + w, 2);      tg = "R4 w-half";        end
        else if (d < -8)  begin p = fdiv(3 * b + w, 4);  tg = "R4 w-quarter";     end
        else              begin p = b;                   tg = "R3 base";          end
        if (p < 0)   begin p = 0;   tg = {tg, " R5 clamp-low"};  end
        if (p > 255) begin p = 255; tg = {tg, " R5 clamp-high"}; end
        e = px - p;
        t = (p < 255 - p) ? p : 255 - p;
        ev[idx] = v;
        eref[idx] = r;
        if (r) begin
            epred[idx] = px; ecode[idx] = px; etag[idx] = "R8 bypass";
        end else begin
            epred[idx] = p;
            etag[idx]  = tg;
            if (e >= 0 && e <= t)      ecode[idx] = 2 * e;
            else if (e < 0 && -e <= t) ecode[idx] = 2 * (-e) - 1;
            else                       ecode[idx] = t + iabs(e);
            if (t == 0) etag[idx] = {etag[idx], " R6 zero-limit"};
        end
    endtask

    task automatic drive(bit v, bit r, int px, int n, int nn, int w,
                         int wn, int ws, int ww, int wsw);
        @(negedge clk);
        check_out();
        in_valid = v; in_ref = r; in_pix = 8'(px);
        nb_n = 8'(n); nb_nn = 8'(nn); nb_w = 8'(w); nb_wn = 8'(wn);
        nb_ws = 8'(ws); nb_ww = 8'(ww); nb_wsw = 8'(wsw);
        model(v, r, px, n, nn, w, wn, ws, ww, wsw);
        idx++;
    endtask

    // Steering d = +k: flat column gradient, cross gradient |n-w|
    task automatic steer_pos(int k, int px);
        drive(1'b1, 1'b0, px, 100 + k, 100 + k, 100, 100, 100, 100, 100);
    endtask

    // Steering d = -k: flat cross gradient, column gradient |nn-n|
    task automatic steer_neg(int k, int px);
        drive(1'b1, 1'b0, px, 100, 100 + k, 100, 100, 100, 100, 100);
    endtask

    function automatic int jit(int c, int s);
        int x;
        x = c + int'($urandom_range(2 * s)) - s;
        if (x < 0) x = 0;
        if (x > 255) x = 255;
        return x;
    endfunction

    initial begin
        #(4 * 150000);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        check("R10 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;

        // R2, R3, R4 boundaries of d on both sides
        steer_pos(81, 150); steer_pos(80, 150); steer_pos(33, 120);
        steer_pos(32, 120); steer_pos(9, 110);  steer_pos(8, 110);
        steer_neg(8, 90);   steer_neg(9, 90);   steer_neg(32, 60);
        steer_neg(33, 60);  steer_neg(80, 10);  steer_neg(81, 10);
        // R5 low clamp and R6 zero limit together: base = -64
        drive(1'b1, 1'b0, 77, 0, 0, 0, 255, 0, 0, 0);
        drive(1'b1, 1'b0, 0, 0, 0, 0, 255, 0, 0, 0);
        // R5 high clamp: base = 318
        drive(1'b1, 1'b0, 200, 255, 255, 255, 0, 255, 255, 255);
        // R5 floor rounding of a negative quarter: ws - wn = -1
        drive(1'b1, 1'b0, 50, 50, 50, 50, 51, 50, 50, 50);
        // R7 fold regions around p = 100
        drive(1'b1, 1'b0, 100, 100, 100, 100, 100, 100, 100, 100);
        drive(1'b1, 1'b0, 103, 100, 100, 100, 100, 100, 100, 100);
        drive(1'b1, 1'b0, 97, 100, 100, 100, 100, 100, 100, 100);
        drive(1'b1, 1'b0, 255, 100, 100, 100, 100, 100, 100, 100);
        drive(1'b1, 1'b0, 0, 100, 100, 100, 100, 100, 100, 100);
        // R8 reference bypass, including the full-scale pixel
        drive(1'b1, 1'b1, 201, 3, 9, 40, 250, 7, 0, 99);
        drive(1'b1, 1'b1, 255, 0, 0, 0, 0, 0, 0, 0);
        // R9 bubble between valid samples
        drive(1'b0, 1'b0, 5, 5, 5, 5, 5, 5, 5, 5);
        drive(1'b1, 1'b0, 5, 5, 5, 5, 5, 5, 5, 5);

        // Seeded random traffic: half wide-open, half smooth neighbourhoods
        for (int i = 0; i < 3000; i++) begin
            int c, s;
            bit v, r;
            v = ($urandom_range(7) != 0);
            r = ($urandom_range(15) == 0);
            if ($urandom_range(1) == 0) begin
                drive(v, r, int'($urandom_range(255)), int'($urandom_range(255)),
                      int'($urandom_range(255)), int'($urandom_range(255)),
                      int'($urandom_range(255)), int'($urandom_range(255)),
                      int'($urandom_range(255)), int'($urandom_range(255)));
            end else begin
                c = int'($urandom_range(255));
                s = int'($urandom_range(40));
                drive(v, r, jit(c, s), jit(c, s), jit(c, s), jit(c, s),
                      jit(c, s), jit(c, s), jit(c, s), jit(c, s));
            end
        end
        repeat (3) drive(1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule